// File: doc/BRIEF.md
# Transmit Descriptor Ring Sequencer

This block owns a ring of transmit buffer descriptors held in an on-chip descriptor memory. A host fills descriptors over a plain 32-bit register bus. Each descriptor is two words: a control/status word and a buffer address. The host hands a descriptor to the block by setting its ready bit. The sequencer walks the ring from index 0. For each ready descriptor it presents one frame request to a MAC transmit engine: the buffer address, the length, and the pad and CRC options. The request is held until the engine answers with a done strobe and a completion status.

When the engine completes, the block merges the status into the descriptor, clears the ready bit so the host can take the descriptor back, and moves to the next index. It returns to index 0 after a descriptor that carries the wrap flag. It can also raise a one-cycle interrupt pulse. A programmable ring-size register splits the one memory: indices below the count form the transmit ring, and the receive side uses the rest. A mode register enables transmission and provides a self-clearing software reset of the ring position.

Top module: `tdr_ring_seq`

## Requirements
- R1: After reset the frame request and both interrupt pulses are low, and the mode register (byte 0x000) and the ring-size register (byte 0x004) read 0.
- R2: A write to the ring-size register stores the written value when it is at most 128 and stores 128 otherwise; reading returns the stored value.
- R3: Descriptor i lives at byte 0x400+8*i: its control/status word at offset 0 and its buffer address at offset 4. Both are host-writable and read back as stored.
- R4: A descriptor is fetched only while transmission is enabled (mode bit 0), its index is below the ring size and its ready bit (bit 15) is 1. The request carries the address word, the length from bits 31:16, pad from bit 12 and CRC append from bit 11. While the ready bit is 0 the sequencer stays on that index and keeps polling it.
- R5: The request stays asserted with unchanged fields until done is sampled high. A done strobe while no request is pending has no effect.
- R6: In the cycle after done is sampled, the stored control/status word gets bit 15 cleared and bits 8:0 replaced by the returned status. Bits 8:0 hold carrier lost (0), deferred (1), late collision (2), retry limit (3), retry count (7:4) and underrun (8). All other bits are kept.
- R7: After completing a descriptor whose bit 13 is set, the next index is 0. Otherwise it is the current index plus one.
- R8: When the completed descriptor had bit 14 set, exactly one one-cycle pulse is raised, in the same cycle as the write-back. It is the error pulse if any of status bits 0, 2, 3 or 8 is set, and the done pulse otherwise. With bit 14 clear, no pulse is raised.
- R9: Clearing mode bit 0 lets an in-flight request finish, then holds the ring index, so no new request starts until the block is re-enabled at the same index.
- R10: Writing mode bit 1 as 1 drops any pending request and returns the ring index to 0 at once. The bit is not stored and reads as 0.
- R11: Host writes to a descriptor that is in flight are stored, but the pending request keeps the fetched values. A control/status write that lands in the write-back cycle is the base into which the status is merged.
- R12: While the ring index is not below the ring size (including size 0), no request starts even if the descriptor there is ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 11 | Host byte address |
| bus_we | input | 1 | Host write strobe |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, combinational from bus_addr |
| req_valid | output | 1 | Frame request to the MAC engine |
| req_addr | output | 32 | Buffer address of the requested frame |
| req_len | output | 16 | Frame length in bytes |
| req_pad | output | 1 | Pad short frames |
| req_crc | output | 1 | Append CRC |
| mac_done | input | 1 | Engine completion strobe |
| mac_status | input | 9 | Completion status, layout as in R6 |
| irq_tx_done | output | 1 | One-cycle completion interrupt |
| irq_tx_err | output | 1 | One-cycle error interrupt |

## Verification
Each result has a fixed latency. A ready descriptor seen at a clock edge gives a request one cycle later. A done sampled at an edge gives the interrupt pulse in the next cycle, and the write-back and index move take effect at the edge that ends that cycle. Register reads are valid in the same cycle as the address. The bench keeps a behavioural model that it advances at each rising edge from the same inputs, and it compares the request and interrupt outputs at every falling edge. Descriptor reads are compared against the model's memory in the cycle the address is applied, so every check samples after the edge that produced its value.

// File: rtl/tdr_pkg.sv
// Shared constants and types for the transmit descriptor ring sequencer.
// Assumes a 32-bit control/status word whose upper 21 bits carry control.
package tdr_pkg;
    localparam int BIT_READY = 15;
    localparam int BIT_IRQ   = 14;
    localparam int BIT_WRAP  = 13;
    localparam int BIT_PAD   = 12;
    localparam int BIT_CRC   = 11;
    localparam int CTL_LSB   = 11;
    localparam int CTL_W     = 32 - CTL_LSB;
    localparam int RES_W     = 9;
    // status bits that count as a failed transmission
    localparam logic [RES_W-1:0] RES_ERR_MASK = 9'h10D;

    typedef enum logic [1:0] {
        SQ_POLL = 2'd0,
        SQ_REQ  = 2'd1,
        SQ_WB   = 2'd2
    } sq_state_t;
endpackage

// File: rtl/tdr_ctrl_regs.sv
// Mode and ring-size registers.
// Holds the transmit enable and the clamped ring size; decodes the
// self-clearing software reset from a mode write. Assumes the caller
// has already decoded the register address into the two write strobes.
module tdr_ctrl_regs #(
    parameter int CNT_MAX = 128,
    parameter int CNT_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_we,
    input  logic             cnt_we,
    input  logic [31:0]      wdata,
    output logic             tx_en,
    output logic             soft_rst,
    output logic [CNT_W-1:0] ring_cnt
);
    // software reset acts in the write cycle only and is never stored
    assign soft_rst = mode_we && wdata[1];

    // register update with clamping of the ring size
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en    <= 1'b0;
            ring_cnt <= '0;
        end else begin
            if (mode_we)
                tx_en <= wdata[0];
            if (cnt_we)
                ring_cnt <= (wdata > 32'(CNT_MAX)) ? CNT_W'(CNT_MAX) : wdata[CNT_W-1:0];
        end
    end

    assert_cnt_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ring_cnt) <= CNT_MAX);
endmodule

// File: rtl/tdr_desc_ram.sv
// Descriptor memory: one array of control/status words, one of addresses.
// Host port reads combinationally and writes on the clock edge; the
// sequencer port reads the current index and merges completion status.
// Assumes NUM_DESC is a power of two. The memory has no reset.
module tdr_desc_ram
    import tdr_pkg::*;
#(
    parameter int NUM_DESC = 128,
    parameter int IDX_W    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_idx,
    input  logic             host_hi,
    input  logic [31:0]      host_wdata,
    output logic [31:0]      host_rdata,
    input  logic [IDX_W-1:0] seq_idx,
    output logic [CTL_W-1:0] seq_ctl,
    output logic [31:0]      seq_addr,
    input  logic             wb_en,
    input  logic [IDX_W-1:0] wb_idx,
    input  logic [RES_W-1:0] wb_res
);
    logic [31:0] stat_mem [NUM_DESC];
    logic [31:0] addr_mem [NUM_DESC];
    logic [31:0] wb_base;
    logic [31:0] wb_word;

    // host read port
    assign host_rdata = host_hi ? addr_mem[host_idx] : stat_mem[host_idx];

    // sequencer read port: control field and address of the current index
    assign seq_ctl  = stat_mem[seq_idx][31:CTL_LSB];
    assign seq_addr = addr_mem[seq_idx];

    // merge base: a host write in the same cycle wins over the stored word
    assign wb_base = (host_we && !host_hi && host_idx == wb_idx) ? host_wdata : stat_mem[wb_idx];
    assign wb_word = {wb_base[31:BIT_READY+1], 1'b0, wb_base[BIT_READY-1:RES_W], wb_res};

    // memory writes: host first, write-back last so it takes precedence
    always_ff @(posedge clk) begin
        if (host_we && host_hi)
            addr_mem[host_idx] <= host_wdata;
        if (host_we && !host_hi)
            stat_mem[host_idx] <= host_wdata;
        if (wb_en)
            stat_mem[wb_idx] <= wb_word;
    end

    assert_wb_clears_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> !stat_mem[$past(wb_idx)][BIT_READY]);
    assert_wb_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> stat_mem[$past(wb_idx)][RES_W-1:0] == $past(wb_res));
endmodule

// File: rtl/tdr_seq.sv
// Ring walker: polls the current index, issues one frame request per
// ready descriptor, waits for done, then writes status back and moves on.
// Assumes the descriptor memory read is combinational on ring_ptr.
module tdr_seq
    import tdr_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             soft_rst,
    input  logic [CNT_W-1:0] ring_cnt,
    input  logic [CTL_W-1:0] fetch_ctl,
    input  logic [31:0]      fetch_addr,
    input  logic             mac_done,
    input  logic [RES_W-1:0] mac_status,
    output logic [IDX_W-1:0] ring_ptr,
    output logic             req_valid,
    output logic [31:0]      req_addr,
    output logic [15:0]      req_len,
    output logic             req_pad,
    output logic             req_crc,
    output logic             wb_en,
    output logic [RES_W-1:0] wb_res,
    output logic             irq_done,
    output logic             irq_err
);
    sq_state_t  state;
    logic       lat_irq;
    logic       lat_wrap;
    logic       fetch_ok;
    logic       res_bad;

    // a descriptor is taken only when enabled, inside the ring and ready
    assign fetch_ok = tx_en && (int'(ring_ptr) < int'(ring_cnt))
                      && fetch_ctl[BIT_READY-CTL_LSB];

    // state, ring index and latched descriptor fields
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            state    <= SQ_POLL;
            ring_ptr <= '0;
            req_addr <= '0;
            req_len  <= '0;
            req_pad  <= 1'b0;
            req_crc  <= 1'b0;
            lat_irq  <= 1'b0;
            lat_wrap <= 1'b0;
            wb_res   <= '0;
        end else begin
            case (state)
                SQ_POLL: if (fetch_ok) begin
                    req_addr <= fetch_addr;
                    req_len  <= fetch_ctl[CTL_W-1:CTL_W-16];
                    req_pad  <= fetch_ctl[BIT_PAD-CTL_LSB];
                    req_crc  <= fetch_ctl[BIT_CRC-CTL_LSB];
                    lat_irq  <= fetch_ctl[BIT_IRQ-CTL_LSB];
                    lat_wrap <= fetch_ctl[BIT_WRAP-CTL_LSB];
                    state    <= SQ_REQ;
                end
                SQ_REQ: if (mac_done) begin
                    wb_res <= mac_status;
                    state  <= SQ_WB;
                end
                SQ_WB: begin
                    ring_ptr <= lat_wrap ? '0 : ring_ptr + 1'b1;
                    state    <= SQ_POLL;
                end
                default: state <= SQ_POLL;
            endcase
        end
    end

    // handshake and interrupt outputs decoded from the state
    assign req_valid = (state == SQ_REQ);
    assign wb_en     = (state == SQ_WB);
    assign res_bad   = |(wb_res & RES_ERR_MASK);
    assign irq_done  = wb_en && lat_irq && !res_bad;
    assign irq_err   = wb_en && lat_irq && res_bad;

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (req_valid && !mac_done) |=> (req_valid && $stable(req_addr) && $stable(req_len)));
    assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_done || irq_err) |=> !(irq_done || irq_err));
    assert_wrap_to_zero_R7: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (wb_en && lat_wrap) |=> (ring_ptr == '0));
    assert_hold_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (!tx_en && state == SQ_POLL) |=> $stable(ring_ptr));
endmodule

// File: rtl/tdr_ring_seq.sv
// Top of the transmit descriptor ring sequencer.
// Decodes the host bus into the control registers and the descriptor
// memory (byte 0x400 upward, 8 bytes per descriptor) and connects the
// ring walker. Assumes word-aligned host accesses; others are ignored.
module tdr_ring_seq
    import tdr_pkg::*;
#(
    parameter int NUM_DESC = 128,
    parameter int CNT_MAX  = 128,
    parameter int ADDR_W   = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              req_valid,
    output logic [31:0]       req_addr,
    output logic [15:0]       req_len,
    output logic              req_pad,
    output logic              req_crc,
    input  logic              mac_done,
    input  logic [8:0]        mac_status,
    output logic              irq_tx_done,
    output logic              irq_tx_err
);
    localparam int IDX_W = $clog2(NUM_DESC);
    localparam int CNT_W = $clog2(CNT_MAX + 1);

    logic             desc_sel, mode_sel, cnt_sel;
    logic             tx_en, soft_rst;
    logic [CNT_W-1:0] ring_cnt;
    logic [31:0]      desc_rdata;
    logic [IDX_W-1:0] ring_ptr;
    logic [CTL_W-1:0] fetch_ctl;
    logic [31:0]      fetch_addr;
    logic             wb_en;
    logic [RES_W-1:0] wb_res;

    // address decode
    assign desc_sel = bus_addr[ADDR_W-1] && (bus_addr[1:0] == 2'b00);
    assign mode_sel = (bus_addr == ADDR_W'(0));
    assign cnt_sel  = (bus_addr == ADDR_W'(4));

    tdr_ctrl_regs #(.CNT_MAX(CNT_MAX), .CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_we  (bus_we && mode_sel),
        .cnt_we   (bus_we && cnt_sel),
        .wdata    (bus_wdata),
        .tx_en    (tx_en),
        .soft_rst (soft_rst),
        .ring_cnt (ring_cnt)
    );

    tdr_desc_ram #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) u_ram (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (bus_we && desc_sel),
        .host_idx   (bus_addr[3 +: IDX_W]),
        .host_hi    (bus_addr[2]),
        .host_wdata (bus_wdata),
        .host_rdata (desc_rdata),
        .seq_idx    (ring_ptr),
        .seq_ctl    (fetch_ctl),
        .seq_addr   (fetch_addr),
        .wb_en      (wb_en),
        .wb_idx     (ring_ptr),
        .wb_res     (wb_res)
    );

    tdr_seq #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .soft_rst   (soft_rst),
        .ring_cnt   (ring_cnt),
        .fetch_ctl  (fetch_ctl),
        .fetch_addr (fetch_addr),
        .mac_done   (mac_done),
        .mac_status (mac_status),
        .ring_ptr   (ring_ptr),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_len    (req_len),
        .req_pad    (req_pad),
        .req_crc    (req_crc),
        .wb_en      (wb_en),
        .wb_res     (wb_res),
        .irq_done   (irq_tx_done),
        .irq_err    (irq_tx_err)
    );

    // host read multiplexer
    always_comb begin
        if (desc_sel)
            bus_rdata = desc_rdata;
        else if (mode_sel)
            bus_rdata = {31'b0, tx_en};
        else if (cnt_sel)
            bus_rdata = 32'(ring_cnt);
        else
            bus_rdata = '0;
    end
endmodule

// File: tb/sim_tdr_ring_seq.sv
module sim_tdr_ring_seq;
    localparam int PERIOD = 10;
    localparam int NUM    = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        req_valid, req_pad, req_crc;
    logic [31:0] req_addr;
    logic [15:0] req_len;
    logic        mac_done = 1'b0;
    logic [8:0]  mac_status = '0;
    logic        irq_tx_done, irq_tx_err;

    int n_chk = 0;
    int n_err = 0;

    always #(PERIOD/2) clk = ~clk;

    tdr_ring_seq u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .req_len(req_len), .req_pad(req_pad),
        .req_crc(req_crc), .mac_done(mac_done), .mac_status(mac_status),
        .irq_tx_done(irq_tx_done), .irq_tx_err(irq_tx_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_stat [NUM];
    logic [31:0] m_addr [NUM];
    bit          m_en, m_busy, m_wb, live;
    int          m_cnt, m_ptr;
    logic [31:0] m_ladr, m_lctl;
    logic [8:0]  m_res;

    initial for (int i = 0; i < NUM; i++) begin m_stat[i] = '0; m_addr[i] = '0; end

    always @(posedge clk) begin
        live <= rst_n;
        if (!rst_n) begin
            m_en = 0; m_cnt = 0; m_ptr = 0; m_busy = 0; m_wb = 0;
        end else begin
            bit hw, hhi, srst, do_wb;
            int hidx, wbi;
            logic [31:0] base, merged;
            hw    = bus_we && bus_addr[10] && bus_addr[1:0] == 2'b00;
            hhi   = bus_addr[2];
            hidx  = int'(bus_addr[9:3]);
            srst  = bus_we && bus_addr == 11'h000 && bus_wdata[1];
            do_wb = 0; wbi = 0; merged = '0;
            if (srst) begin
                m_ptr = 0; m_busy = 0; m_wb = 0;
            end else if (m_wb) begin
                base   = (hw && !hhi && hidx == m_ptr) ? bus_wdata : m_stat[m_ptr];
                merged = (base & ~32'h0000_81FF) | 32'(m_res);
                wbi = m_ptr; do_wb = 1;
                m_ptr = m_lctl[13] ? 0 : (m_ptr + 1) % NUM;
                m_wb = 0;
            end else if (m_busy) begin
                if (mac_done) begin m_res = mac_status; m_busy = 0; m_wb = 1; end
            end else if (m_en && m_ptr < m_cnt && m_stat[m_ptr][15]) begin
                m_lctl = m_stat[m_ptr]; m_ladr = m_addr[m_ptr]; m_busy = 1;
            end
            if (hw) begin
                if (hhi) m_addr[hidx] = bus_wdata; else m_stat[hidx] = bus_wdata;
            end
            if (do_wb) m_stat[wbi] = merged;
            if (bus_we && bus_addr == 11'h000) m_en = bus_wdata[0];
            if (bus_we && bus_addr == 11'h004) m_cnt = (bus_wdata > 128) ? 128 : int'(bus_wdata);
        end
    end

    // per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (live) begin
            bit bad;
            bad = |(m_res & 9'h10D);
            chk("R4 req_valid", 32'(req_valid), 32'(m_busy));
            if (m_busy) begin
                chk("R4 req_addr", req_addr, m_ladr);
                chk("R4 req_len", 32'(req_len), 32'(m_lctl[31:16]));
                chk("R4 req_pad", 32'(req_pad), 32'(m_lctl[12]));
                chk("R4 req_crc", 32'(req_crc), 32'(m_lctl[11]));
            end
            chk("R8 irq_done", 32'(irq_tx_done), 32'(m_wb && m_lctl[14] && !bad));
            chk("R8 irq_err", 32'(irq_tx_err), 32'(m_wb && m_lctl[14] && bad));
        end
    end

    // ---------------- stimulus helpers (called at a falling edge) ----------------
    task automatic wr(input logic [10:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [10:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_req(input string tag);
        int t = 0;
        while (!req_valid && t < 50) begin @(negedge clk); t++; end
        chk(tag, 32'(req_valid), 32'd1);
    endtask

    task automatic finish_frame(input string tag, input logic [8:0] st, input int dly,
                                input bit exp_done, input bit exp_err);
        idle(dly);
        mac_done = 1'b1; mac_status = st;
        @(negedge clk);
        mac_done = 1'b0;
        chk(tag, {30'b0, irq_tx_err, irq_tx_done}, {30'b0, exp_err, exp_done});
        @(negedge clk);
    endtask

    function automatic logic [10:0] ds(input int i);
        return 11'h400 + 11'(8 * i);
    endfunction

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 req_valid", 32'(req_valid), 0);
        chk("R1 irq", {30'b0, irq_tx_err, irq_tx_done}, 0);
        rd("R1 mode", 11'h000, 0);
        rd("R1 count", 11'h004, 0);
        // R2 ring-size clamp
        wr(11'h004, 32'd300);
        rd("R2 clamp", 11'h004, 32'd128);
        wr(11'h004, 32'd4);
        rd("R2 count", 11'h004, 32'd4);
        // R3 descriptor layout
        wr(ds(0), 32'h0040_C800); wr(ds(0) + 4, 32'h0000_1000);
        wr(ds(1), 32'h0100_D000); wr(ds(1) + 4, 32'h0000_1100);
        wr(ds(2), 32'h003C_5800); wr(ds(2) + 4, 32'h0000_1200);
        wr(ds(3), 32'h05EA_A000); wr(ds(3) + 4, 32'h0000_1300);
        rd("R3 stat1", ds(1), 32'h0100_D000);
        rd("R3 addr3", ds(3) + 4, 32'h0000_1300);
        // enable; descriptor 0
        wr(11'h000, 32'h1);
        wait_req("R4 fetch0");
        chk("R4 addr0", req_addr, 32'h1000);
        finish_frame("R8 ok pulse", 9'h000, 3, 1, 0);
        rd("R6 wb0", ds(0), 32'h0040_4800);
        // descriptor 1 with host writes while in flight
        wait_req("R4 fetch1");
        chk("R4 len1", 32'(req_len), 32'h100);
        wr(ds(1) + 4, 32'h0000_9999);
        wr(ds(1), 32'h0020_C000);
        chk("R11 addr kept", req_addr, 32'h1100);
        finish_frame("R8 err pulse", 9'h014, 2, 0, 1);
        rd("R11 merged", ds(1), 32'h0020_4014);
        rd("R3 addr1", ds(1) + 4, 32'h0000_9999);
        // descriptor 2 not ready: polling, stray done ignored
        idle(6);
        chk("R4 idle", 32'(req_valid), 0);
        mac_done = 1'b1; mac_status = 9'h1FF;
        @(negedge clk);
        mac_done = 1'b0;
        idle(2);
        chk("R5 stray done", 32'(req_valid), 0);
        rd("R5 stat2 kept", ds(2), 32'h003C_5800);
        wr(ds(2), 32'h003C_D800);
        wait_req("R4 fetch2");
        chk("R4 addr2", req_addr, 32'h1200);
        idle(4);
        chk("R5 held", req_addr, 32'h1200);
        finish_frame("R8 retry only", 9'h010, 0, 1, 0);
        // descriptor 3: wrap, no interrupt
        wait_req("R4 fetch3");
        finish_frame("R8 no irq bit", 9'h100, 1, 0, 0);
        rd("R6 wb3", ds(3), 32'h05EA_2100);
        idle(3);
        chk("R7 idle at 0", 32'(req_valid), 0);
        wr(ds(0), 32'h0040_C800);
        wait_req("R7 fetch");
        chk("R7 wrapped", req_addr, 32'h1000);
        // disable mid-request
        wr(11'h000, 32'h0);
        chk("R9 in flight", 32'(req_valid), 1);
        finish_frame("R9 finish", 9'h000, 1, 1, 0);
        wr(ds(1), 32'h0020_C000);
        idle(8);
        chk("R9 held", 32'(req_valid), 0);
        wr(11'h000, 32'h1);
        wait_req("R9 resume");
        chk("R9 same index", req_addr, 32'h9999);
        // software reset mid-request
        wr(11'h000, 32'h3);
        chk("R10 dropped", 32'(req_valid), 0);
        rd("R10 mode", 11'h000, 32'h1);
        idle(3);
        chk("R10 idle at 0", 32'(req_valid), 0);
        wr(ds(0), 32'h0040_C800);
        wait_req("R10 fetch");
        chk("R10 index 0", req_addr, 32'h1000);
        finish_frame("R10 finish0", 9'h000, 0, 1, 0);
        wait_req("R10 fetch1");
        finish_frame("R10 finish1", 9'h000, 0, 1, 0);
        // ring size below index
        wr(11'h004, 32'd1);
        wr(ds(2), 32'h003C_D800);
        idle(8);
        chk("R12 outside", 32'(req_valid), 0);
        wr(11'h004, 32'd4);
        wait_req("R12 inside");
        chk("R12 addr", req_addr, 32'h1200);
        finish_frame("R12 finish", 9'h000, 0, 1, 0);
        idle(3);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        n_err++; n_chk++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule